// File: doc/BRIEF.md
# Serial Channel Status and Interrupt Register

This block keeps the status word and the interrupt control word of one serial channel and drives that channel's single interrupt request. It watches the four incoming modem lines (carrier detect, data set ready, clear to send, ring indicator), the receive data-available and receive-overrun levels, and the transmit FIFO empty level. Each modem line passes through a synchronizer, and a change in either direction is latched into a sticky event bit. The transmit-empty condition is also latched, but only while transmit interrupts are enabled.

Software sees two 32-bit words behind a one-bit address. Address 0 is the status word. In that word, live levels and sticky event bits sit side by side. Writing a 1 clears an event bit. Writing to a live bit does nothing, so a handler can write back the word it has just read and clear exactly the events it saw. Address 1 is the control word. It holds the three interrupt enables and the four modem-side outputs (RTS, DTR, loopback, break). The interrupt request is the OR of every latched or live cause gated by its enable.

Top module: `sio_chan_status`

## Requirements
- R1: Status bit 0 reads rx_avail_i and bit 13 reads rx_ovr_i in the same cycle. Bits 3, 4, 5 and 6 read the synchronized DCD, DSR, CTS and RI levels, which become visible two clock edges after an input change.
- R2: A rising or falling change on a modem input sets its event bit on the third clock edge after the change. The event bits are DSR at bit 16, CTS at bit 17, DCD at bit 18 and RI at bit 22.
- R3: A status write (addr_i=0) with a 1 in an event position (16, 17, 18, 22, 25) clears that bit at the write edge. A 0 in that position leaves the bit unchanged.
- R4: Status writes have no effect on the live bits 0, 3 to 6 and 13. Writing back a value just read clears only the events it contained.
- R5: When an event bit is set and cleared by a write in the same cycle, the bit stays set.
- R6: Status bit 25 is set on each edge where tx_empty_i is 1 and control bit 19 is 1. It is never set while control bit 19 is 0.
- R7: The control word (addr_i=1) stores bits 0, 2, 19, 25, 26, 27 and 28 on a write. All other bits read 0.
- R8: rts_o, dtr_o, loop_o and brk_o follow control bits 25, 26, 27 and 28 from the write edge on.
- R9: irq_o is 1 exactly when at least one of these holds: any modem event bit is set and control bit 0 is set; status bit 0 is 1 and control bit 2 is set; status bit 25 is set and control bit 19 is set.
- R10: After reset, every event bit, the whole control word, irq_o and the four modem outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dcd_i | input | 1 | Carrier detect line, asynchronous |
| dsr_i | input | 1 | Data set ready line, asynchronous |
| cts_i | input | 1 | Clear to send line, asynchronous |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| rx_avail_i | input | 1 | Receive FIFO holds data |
| rx_ovr_i | input | 1 | Receive overrun level |
| tx_empty_i | input | 1 | Transmit FIFO empty level |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Word select: 0 status, 1 control |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the selected word |
| irq_o | output | 1 | Channel interrupt request |
| rts_o | output | 1 | RTS output level |
| dtr_o | output | 1 | DTR output level |
| loop_o | output | 1 | Loopback enable |
| brk_o | output | 1 | Break enable |

## Verification
Two things can touch the same sticky bit on the same clock edge: the hardware setting an event, and a software write-1 clearing it. The bench forces this on the transmit-empty bit. It keeps tx_empty_i high with the transmit enable on, so the bit is being set on every edge, and writes a 1 to bit 25 in the same cycle. It then reads the bit back and expects it still set. Next it drops the enable, repeats the write, and expects the bit cleared with irq_o low. This shows that the clear works once the setting cause has stopped.

// File: rtl/sio_stat_pkg.sv
// Package: bit positions and shared types of the serial channel status and
// control words. Positions are fixed because software decodes them.
package sio_stat_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned N_MDM = 4;   // line index: 0 DCD, 1 DSR, 2 CTS, 3 RI

    // status word
    localparam int unsigned ST_RXAV = 0;
    localparam int unsigned ST_OVR  = 13;
    localparam int unsigned ST_TXE  = 25;

    // control word
    localparam int unsigned CT_MSIE = 0;
    localparam int unsigned CT_RXIE = 2;
    localparam int unsigned CT_TXIE = 19;
    localparam int unsigned CT_RTS  = 25;
    localparam int unsigned CT_DTR  = 26;
    localparam int unsigned CT_LOOP = 27;
    localparam int unsigned CT_BRK  = 28;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << CT_MSIE) | (REG_W'(1) << CT_RXIE) | (REG_W'(1) << CT_TXIE) |
        (REG_W'(1) << CT_RTS)  | (REG_W'(1) << CT_DTR)  | (REG_W'(1) << CT_LOOP) |
        (REG_W'(1) << CT_BRK);

    typedef enum logic {
        SEL_STAT = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic brk;
        logic loop;
        logic dtr;
        logic rts;
    } mdm_out_t;

    // Status position of the live level of modem line idx.
    function automatic int unsigned mdm_live_pos(input int unsigned idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            default: return 6;
        endcase
    endfunction

    // Status position of the change event of modem line idx.
    function automatic int unsigned mdm_chg_pos(input int unsigned idx);
        case (idx)
            0:       return 18;
            1:       return 16;
            2:       return 17;
            default: return 22;
        endcase
    endfunction

endpackage

// File: rtl/sio_sync.sv
// Module: sio_sync
// Multi-stage synchronizer for a vector of asynchronous levels.
// Assumes STAGES >= 2. Each bit is treated on its own; the bits are not
// kept coherent with each other.
module sio_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift the sampled levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/sio_event_bit.sv
// Module: sio_event_bit
// One sticky event flag. set_i sets it and clr_i (a write-1 from software)
// clears it. When both are present in the same cycle, set wins.
module sio_event_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    // Hold the flag; a same-cycle set overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q & ~clr_i) | set_i;
    end

    assign flag_o = flag_q;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    // R3
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/sio_ctl_reg.sv
// Module: sio_ctl_reg
// Channel control word. Only the bits implemented in CTRL_MASK are stored.
// Breaks out the three interrupt enables and the modem-side outputs.
module sio_ctl_reg
    import sio_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] ctl_o,
    output logic             msie_o,
    output logic             rxie_o,
    output logic             txie_o,
    output mdm_out_t         pins_o
);

    logic [REG_W-1:0] ctl_q;

    // Store the implemented control bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    ctl_q <= '0;
        else if (wr_i) ctl_q <= wdata_i & CTRL_MASK;
    end

    assign ctl_o       = ctl_q;
    assign msie_o      = ctl_q[CT_MSIE];
    assign rxie_o      = ctl_q[CT_RXIE];
    assign txie_o      = ctl_q[CT_TXIE];
    assign pins_o.rts  = ctl_q[CT_RTS];
    assign pins_o.dtr  = ctl_q[CT_DTR];
    assign pins_o.loop = ctl_q[CT_LOOP];
    assign pins_o.brk  = ctl_q[CT_BRK];

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((ctl_o & ~CTRL_MASK) == '0));

endmodule

// File: rtl/sio_chan_status.sv
// Module: sio_chan_status
// Status and interrupt register of one serial channel. Synchronizes the modem
// lines and latches their changes. Latches transmit-empty while its enable is
// on. Serves the status word (address 0) and the control word (address 1)
// and combines causes and enables into irq_o. The modem inputs are assumed
// asynchronous; the other inputs are assumed to come from this clock domain.
module sio_chan_status
    import sio_stat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dcd_i,
    input  logic             dsr_i,
    input  logic             cts_i,
    input  logic             ri_i,
    input  logic             rx_avail_i,
    input  logic             rx_ovr_i,
    input  logic             tx_empty_i,
    input  logic             wr_en_i,
    input  logic             addr_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output logic             irq_o,
    output logic             rts_o,
    output logic             dtr_o,
    output logic             loop_o,
    output logic             brk_o
);

    reg_sel_e         sel;
    logic             wr_stat, wr_ctl;
    logic [N_MDM-1:0] mdm_raw, mdm_sync, mdm_prev_q, mdm_chg;
    logic             tx_evt;
    logic             msie, rxie, txie;
    logic [REG_W-1:0] ctl_word, stat_word;
    mdm_out_t         pins;

    assign sel     = reg_sel_e'(addr_i);
    assign wr_stat = wr_en_i && (sel == SEL_STAT);
    assign wr_ctl  = wr_en_i && (sel == SEL_CTRL);
    assign mdm_raw = {ri_i, cts_i, dsr_i, dcd_i};

    sio_sync #(
        .STAGES (SYNC_STAGES),
        .W      (N_MDM)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (mdm_raw),
        .q_o   (mdm_sync)
    );

    // Remember the last synchronized modem levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) mdm_prev_q <= '0;
        else        mdm_prev_q <= mdm_sync;
    end

    // One sticky change flag per modem line, cleared by a write-1 at its position.
    generate
        for (genvar i = 0; i < N_MDM; i++) begin : g_mdm
            localparam int unsigned CP = mdm_chg_pos(i);
            sio_event_bit u_chg (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (mdm_sync[i] ^ mdm_prev_q[i]),
                .clr_i  (wr_stat && wdata_i[CP]),
                .flag_o (mdm_chg[i])
            );
        end
    endgenerate

    sio_event_bit u_txe (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tx_empty_i && txie),
        .clr_i  (wr_stat && wdata_i[ST_TXE]),
        .flag_o (tx_evt)
    );

    sio_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_ctl),
        .wdata_i (wdata_i),
        .ctl_o   (ctl_word),
        .msie_o  (msie),
        .rxie_o  (rxie),
        .txie_o  (txie),
        .pins_o  (pins)
    );

    // Assemble the status word from live levels and sticky events.
    always_comb begin
        stat_word          = '0;
        stat_word[ST_RXAV] = rx_avail_i;
        stat_word[ST_OVR]  = rx_ovr_i;
        stat_word[ST_TXE]  = tx_evt;
        for (int i = 0; i < N_MDM; i++) begin
            stat_word[mdm_live_pos(i)] = mdm_sync[i];
            stat_word[mdm_chg_pos(i)]  = mdm_chg[i];
        end
    end

    // Read mux of the two words.
    assign rdata_o = (sel == SEL_STAT) ? stat_word : ctl_word;

    // Interrupt request: each cause gated by its enable.
    assign irq_o = ((|mdm_chg) && msie) || (rx_avail_i && rxie) || (tx_evt && txie);

    assign rts_o  = pins.rts;
    assign dtr_o  = pins.dtr;
    assign loop_o = pins.loop;
    assign brk_o  = pins.brk;

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(msie || rxie || txie) |-> !irq_o);

    // R6
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_evt) |-> $past(txie && tx_empty_i));

    // R8
    pin_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctl |=> (rts_o == $past(wdata_i[CT_RTS]) && brk_o == $past(wdata_i[CT_BRK])));

endmodule

// File: tb/sim_sio_chan_status.sv
`timescale 1ns/1ps
module sim_sio_chan_status;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dcd = 0, dsr = 0, cts = 0, ri = 0;
    logic        rx_avail = 0, rx_ovr = 0, tx_empty = 0;
    logic        wr_en = 0, addr = 0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rts, dtr, lpb, brk;

    always #2.5 clk = ~clk;

    sio_chan_status u0 (
        .clk(clk), .rst_n(rst_n),
        .dcd_i(dcd), .dsr_i(dsr), .cts_i(cts), .ri_i(ri),
        .rx_avail_i(rx_avail), .rx_ovr_i(rx_ovr), .tx_empty_i(tx_empty),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq),
        .rts_o(rts), .dtr_o(dtr), .loop_o(lpb), .brk_o(brk)
    );

    // scoreboard item: kind 0 = read word, 1 = irq, 2 = {brk,loop,dtr,rts}
    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    errors = 0;
    int    checks = 0;
    bit    done = 0;

    // Monitor: pop expected items and compare with the outputs.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        while (q.size() > 0) begin
            it = q.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = {31'd0, irq};
                default: act = {28'd0, brk, lpb, dtr, rts};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
        wdata = '0;
    endtask

    // Driver: push an expectation; the monitor judges it at the next negedge.
    task automatic chk(input int kind, input logic a, input logic [31:0] e, input string tag);
        item_t it;
        addr    = a;
        it.kind = kind;
        it.exp  = e;
        it.tag  = tag;
        q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();

        // R10 reset state
        chk(0, 0, 32'h0, "R10 status after reset");
        chk(0, 1, 32'h0, "R10 control after reset");
        chk(1, 0, 32'h0, "R10 irq after reset");
        chk(2, 0, 32'h0, "R10 modem outputs after reset");

        // R7 / R8 control storage and outputs
        wr(1, 32'hFFFF_FFFF);
        chk(0, 1, 32'h1E08_0005, "R7 control implemented bits");
        chk(2, 0, 32'hF, "R8 all modem outputs on");
        wr(1, 32'h0A00_0000);
        chk(2, 0, 32'h5, "R8 rts and loop only");
        wr(1, 32'h0);

        // R1 live receive levels, R9 receive interrupt
        rx_avail = 1;
        rx_ovr   = 1;
        chk(0, 0, 32'h0000_2001, "R1 rx available and overrun live");
        chk(1, 0, 32'h0, "R9 rx cause masked");
        wr(1, 32'h4);
        chk(1, 0, 32'h1, "R9 rx cause enabled");
        wr(0, 32'hFFFF_FFFF);
        chk(0, 0, 32'h0000_2001, "R4 live rx bits ignore writes");
        rx_avail = 0;
        rx_ovr   = 0;
        chk(1, 0, 32'h0, "R9 rx cause gone");
        wr(1, 32'h0);

        // R1 / R2 modem DSR rising edge timing
        dsr = 1;
        chk(0, 0, 32'h0, "R1 DSR not yet visible");
        tick();
        chk(0, 0, 32'h0, "R1 DSR after one edge");
        tick();
        chk(0, 0, 32'h0000_0010, "R1 DSR live after two edges");
        tick();
        chk(0, 0, 32'h0001_0010, "R2 DSR change after three edges");
        chk(1, 0, 32'h0, "R9 modem cause masked");
        wr(1, 32'h1);
        chk(1, 0, 32'h1, "R9 modem cause enabled");
        wr(0, 32'h0001_0010);
        chk(0, 0, 32'h0000_0010, "R4 write-back clears only the event");
        chk(1, 0, 32'h0, "R9 irq drops after clear");

        // R2 falling edge also latches
        dsr = 0;
        tick(3);
        chk(0, 0, 32'h0001_0000, "R2 DSR falling edge latched");
        wr(0, 32'h0001_0000);
        chk(0, 0, 32'h0, "R3 DSR event cleared");

        // R2 all four lines, positions
        dcd = 1; cts = 1; ri = 1; dsr = 1;
        tick(3);
        chk(0, 0, 32'h0047_0078, "R2 all four change bits and levels");
        wr(0, 32'h0);
        chk(0, 0, 32'h0047_0078, "R3 zero write keeps events");
        wr(0, 32'h0002_0000);
        chk(0, 0, 32'h0045_0078, "R3 clear CTS event only");
        chk(1, 0, 32'h1, "R9 remaining events keep irq");
        wr(0, 32'h0045_0078);
        chk(0, 0, 32'h0000_0078, "R4 write-back leaves live levels");
        chk(1, 0, 32'h0, "R9 no events left");
        wr(1, 32'h0);

        // R6 transmit-empty gated by its enable
        tx_empty = 1;
        tick(2);
        chk(0, 0, 32'h0000_0078, "R6 no tx event while disabled");
        wr(1, 32'h0008_0000);
        chk(0, 0, 32'h0000_0078, "R6 tx event not yet set");
        tick();
        chk(0, 0, 32'h0200_0078, "R6 tx event set");
        chk(1, 0, 32'h1, "R9 tx cause enabled");

        // R5 set and clear in the same cycle
        wr(0, 32'h0200_0000);
        chk(0, 0, 32'h0200_0078, "R5 set wins over clear");
        wr(1, 32'h0);
        wr(0, 32'h0200_0000);
        chk(0, 0, 32'h0000_0078, "R3 tx event cleared after disable");
        chk(1, 0, 32'h0, "R9 irq low after tx clear");
        tick(2);
        chk(0, 0, 32'h0000_0078, "R6 tx event stays clear while disabled");

        tick(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule